// File: doc/BRIEF.md
# Two-Level Split-L1 Miss Profiler

This block counts cache misses for a machine that has separate instruction and data first-level caches in front of one shared last-level cache. It holds tags only; no data moves through it. Each request arrives on the instruction port or the data port as a byte address and a byte count. The request is looked up in the first-level tracker for its own port. Every tracker keeps per-set tags in least-recently-used order and allocates a line on every miss.

When the first-level lookup misses, the same address and byte count go to the shared last-level tracker. That tracker has its own line size, set count and associativity. A request that crosses one line boundary is looked up in both lines, but it counts as a single access: it is a miss if either line misses.

Two wide counters hold the number of first-level misses and the number of last-level misses. A request that covers more than two lines is reported on a sticky error flag and is not counted. Each port completes one request at a time and signals completion with a one-cycle done pulse.

Top module: `split_miss_profiler`

## Requirements
- R1: An instruction request looks up and updates only the instruction first-level tracker, and a data request only the data tracker; each tracker has its own line size, set count and way count.
- R2: A first-level access that misses adds exactly one to the first-level miss count, even when it straddles two lines and both lines miss. A straddling access in which both lines hit counts as a hit.
- R3: After a first-level miss, the same address and byte count are looked up in the shared last-level tracker, using that tracker's own line split and straddle rule. The last-level count rises by one only when that lookup misses.
- R4: A first-level hit makes no last-level access, so the last-level count and last-level contents are unchanged.
- R5: Each set replaces its least recently used line on a miss. A hit moves the hit line to most recently used.
- R6: When both ports are waiting for the last level, the data port is served first. The instruction request keeps its address and byte count until it is granted.
- R7: Every accepted request produces exactly one done pulse on its own port. A request strobe that arrives while that port is still busy, including during its last-level lookup, is ignored.
- R8: A request whose bytes cover more than two lines at any level sets the error output, which stays set until reset. That request changes neither counter.
- R9: Synchronous reset clears both counters and the error output, and marks every line in all three trackers as invalid.
- R10: When both ports finish a first-level miss in the same cycle, the first-level count rises by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iReq | input | 1 | Instruction request strobe |
| iAddr | input | ADDR_W | Instruction byte address |
| iSize | input | SIZE_W | Instruction byte count (at least 1) |
| dReq | input | 1 | Data request strobe |
| dAddr | input | ADDR_W | Data byte address |
| dSize | input | SIZE_W | Data byte count (at least 1) |
| iDone | output | 1 | Instruction request complete (one-cycle pulse) |
| dDone | output | 1 | Data request complete (one-cycle pulse) |
| l1Misses | output | CNT_W | First-level miss count |
| llMisses | output | CNT_W | Last-level miss count |
| spanErr | output | 1 | Sticky error: a request covered more than two lines |

## Verification
The assertions assume that every byte count is at least one and that no request wraps past the top of the address space. They also assume that the last-level line is no shorter than either first-level line, so that an over-wide request is always caught at the first level. The stimulus uses byte counts from 1 to 10 and addresses in the low kilobyte only. Its one over-wide request is chosen so that it spans three instruction lines.

// File: rtl/miss_prof_pkg.sv
package miss_prof_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic iStart;
    logic dStart;
    logic grantI;
    logic grantD;
    logic incL1I;
    logic incL1D;
    logic incLL;
    logic setErr;
  } strobes_t;

  // status from one tag tracker
  typedef struct packed {
    logic done;
    logic miss;
    logic err;
  } trkStat_t;

  typedef enum logic [1:0] {P_IDLE, P_L1, P_WAIT, P_LL} portSt_t;
endpackage

// File: rtl/lru_tag_tracker.sv
module lru_tag_tracker #(
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 4,
  parameter int LINE_LOG2 = 4,
  parameter int SETS_LOG2 = 2,
  parameter int WAYS      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              done,
  output logic              miss,
  output logic              err
);
  localparam int LINE_W = ADDR_W - LINE_LOG2;
  localparam int TAG_W  = LINE_W - SETS_LOG2;
  localparam int SETS   = 1 << SETS_LOG2;

  typedef enum logic [1:0] {T_IDLE, T_FIRST, T_SECOND, T_ERR} trk_t;
  trk_t state;
  logic [LINE_W-1:0] lineQ;
  logic straddleQ, missQ;
  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [WAYS-1:0]  vldMem [SETS];

  logic [ADDR_W-1:0] lastByte;
  logic [LINE_W-1:0] firstLine, lastLine, lineSpan;
  logic [SETS_LOG2-1:0] setIdx;
  logic [TAG_W-1:0] curTag;
  logic lookup, hitAny, curMiss;
  int hitPos;

  always_comb begin
    lastByte  = addr + ADDR_W'(size) - ADDR_W'(1);
    firstLine = addr[ADDR_W-1:LINE_LOG2];
    lastLine  = lastByte[ADDR_W-1:LINE_LOG2];
    lineSpan  = lastLine - firstLine;
    setIdx    = lineQ[SETS_LOG2-1:0];
    curTag    = lineQ[LINE_W-1:SETS_LOG2];
    lookup    = (state == T_FIRST) || (state == T_SECOND);
    hitAny    = 1'b0;
    hitPos    = WAYS - 1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vldMem[setIdx][w] && tagMem[setIdx][w] == curTag) begin
        hitAny = 1'b1;
        hitPos = w;
      end
    end
    curMiss = lookup && !hitAny;
    done    = (state == T_FIRST && !straddleQ) || state == T_SECOND || state == T_ERR;
    miss    = curMiss || (state == T_SECOND && missQ);
    err     = (state == T_ERR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= T_IDLE;
      lineQ     <= '0;
      straddleQ <= 1'b0;
      missQ     <= 1'b0;
      for (int s = 0; s < SETS; s++) vldMem[s] <= '0;
    end else begin
      case (state)
        T_IDLE: if (start) begin
          lineQ     <= firstLine;
          straddleQ <= (lineSpan == LINE_W'(1));
          state     <= (lineSpan > LINE_W'(1)) ? T_ERR : T_FIRST;
        end
        T_FIRST: begin
          missQ <= curMiss;
          if (straddleQ) begin
            lineQ <= lineQ + LINE_W'(1);
            state <= T_SECOND;
          end else state <= T_IDLE;
        end
        default: state <= T_IDLE;
      endcase
      if (lookup) begin
        for (int w = 1; w < WAYS; w++)
          if (w <= hitPos) vldMem[setIdx][w] <= vldMem[setIdx][w-1];
        vldMem[setIdx][0] <= 1'b1;
      end
    end
  end

  // tag payload needs no reset: valid bits gate it
  always_ff @(posedge clk) begin
    if (!rst && lookup) begin
      for (int w = 1; w < WAYS; w++)
        if (w <= hitPos) tagMem[setIdx][w] <= tagMem[setIdx][w-1];
      tagMem[setIdx][0] <= curTag;
    end
  end
endmodule

// File: rtl/miss_prof_datapath.sv
module miss_prof_datapath
  import miss_prof_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4,
  parameter int CNT_W  = 64,
  parameter int IL_LOG2 = 3, parameter int IS_LOG2 = 1, parameter int IWAYS = 2,
  parameter int DL_LOG2 = 4, parameter int DS_LOG2 = 2, parameter int DWAYS = 2,
  parameter int LL_LOG2 = 5, parameter int LS_LOG2 = 2, parameter int LWAYS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic [SIZE_W-1:0] iSize,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [SIZE_W-1:0] dSize,
  output trkStat_t          iStat,
  output trkStat_t          dStat,
  output trkStat_t          llStat,
  output logic [CNT_W-1:0]  l1Misses,
  output logic [CNT_W-1:0]  llMisses,
  output logic              spanErr
);
  logic [ADDR_W-1:0] iAddrQ, dAddrQ, llAddr;
  logic [SIZE_W-1:0] iSizeQ, dSizeQ, llSize;

  always_comb begin
    llAddr = stb.grantD ? dAddrQ : iAddrQ;
    llSize = stb.grantD ? dSizeQ : iSizeQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iAddrQ <= '0; iSizeQ <= '0; dAddrQ <= '0; dSizeQ <= '0;
      l1Misses <= '0; llMisses <= '0; spanErr <= 1'b0;
    end else begin
      if (stb.iStart) begin iAddrQ <= iAddr; iSizeQ <= iSize; end
      if (stb.dStart) begin dAddrQ <= dAddr; dSizeQ <= dSize; end
      l1Misses <= l1Misses + CNT_W'(stb.incL1I) + CNT_W'(stb.incL1D);
      llMisses <= llMisses + CNT_W'(stb.incLL);
      if (stb.setErr) spanErr <= 1'b1;
    end
  end

  lru_tag_tracker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_LOG2(IL_LOG2),
    .SETS_LOG2(IS_LOG2), .WAYS(IWAYS)) uInstL1 (
    .clk(clk), .rst(rst), .start(stb.iStart), .addr(iAddr), .size(iSize),
    .done(iStat.done), .miss(iStat.miss), .err(iStat.err));

  lru_tag_tracker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_LOG2(DL_LOG2),
    .SETS_LOG2(DS_LOG2), .WAYS(DWAYS)) uDataL1 (
    .clk(clk), .rst(rst), .start(stb.dStart), .addr(dAddr), .size(dSize),
    .done(dStat.done), .miss(dStat.miss), .err(dStat.err));

  lru_tag_tracker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_LOG2(LL_LOG2),
    .SETS_LOG2(LS_LOG2), .WAYS(LWAYS)) uLastLvl (
    .clk(clk), .rst(rst), .start(stb.grantI || stb.grantD), .addr(llAddr), .size(llSize),
    .done(llStat.done), .miss(llStat.miss), .err(llStat.err));
endmodule

// File: rtl/miss_prof_control.sv
module miss_prof_control
  import miss_prof_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     iReq,
  input  logic     dReq,
  input  trkStat_t iStat,
  input  trkStat_t dStat,
  input  trkStat_t llStat,
  output strobes_t stb,
  output logic     iDone,
  output logic     dDone
);
  portSt_t iSt, dSt;
  logic llBusy, llOwnerD;
  logic iL1End, dL1End, llEnd, iFinish, dFinish;

  function automatic portSt_t stepPort(portSt_t cur, logic start, logic l1End,
                                       logic fwd, logic grant, logic llMine);
    case (cur)
      P_IDLE:  return start ? P_L1 : P_IDLE;
      P_L1:    return l1End ? (fwd ? P_WAIT : P_IDLE) : P_L1;
      P_WAIT:  return grant ? P_LL : P_WAIT;
      default: return llMine ? P_IDLE : P_LL;
    endcase
  endfunction

  always_comb begin
    stb        = '0;
    stb.iStart = iReq && iSt == P_IDLE;
    stb.dStart = dReq && dSt == P_IDLE;
    stb.grantD = dSt == P_WAIT && !llBusy;
    stb.grantI = iSt == P_WAIT && !llBusy && !stb.grantD;
    iL1End     = iSt == P_L1 && iStat.done;
    dL1End     = dSt == P_L1 && dStat.done;
    llEnd      = llBusy && llStat.done;
    stb.incL1I = iL1End && iStat.miss && !iStat.err;
    stb.incL1D = dL1End && dStat.miss && !dStat.err;
    stb.incLL  = llEnd && llStat.miss && !llStat.err;
    stb.setErr = (iL1End && iStat.err) || (dL1End && dStat.err) || (llEnd && llStat.err);
    iFinish    = (iL1End && !stb.incL1I) || (llEnd && !llOwnerD);
    dFinish    = (dL1End && !stb.incL1D) || (llEnd && llOwnerD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iSt <= P_IDLE; dSt <= P_IDLE;
      llBusy <= 1'b0; llOwnerD <= 1'b0;
      iDone <= 1'b0; dDone <= 1'b0;
    end else begin
      iSt <= stepPort(iSt, stb.iStart, iL1End, stb.incL1I, stb.grantI, llEnd && !llOwnerD);
      dSt <= stepPort(dSt, stb.dStart, dL1End, stb.incL1D, stb.grantD, llEnd && llOwnerD);
      if (stb.grantI || stb.grantD) begin
        llBusy   <= 1'b1;
        llOwnerD <= stb.grantD;
      end else if (llEnd) llBusy <= 1'b0;
      iDone <= iFinish;
      dDone <= dFinish;
    end
  end
endmodule

// File: rtl/split_miss_profiler.sv
module split_miss_profiler
  import miss_prof_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4,
  parameter int CNT_W  = 64,
  parameter int IL_LOG2 = 3, parameter int IS_LOG2 = 1, parameter int IWAYS = 2,
  parameter int DL_LOG2 = 4, parameter int DS_LOG2 = 2, parameter int DWAYS = 2,
  parameter int LL_LOG2 = 5, parameter int LS_LOG2 = 2, parameter int LWAYS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iReq,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic [SIZE_W-1:0] iSize,
  input  logic              dReq,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [SIZE_W-1:0] dSize,
  output logic              iDone,
  output logic              dDone,
  output logic [CNT_W-1:0]  l1Misses,
  output logic [CNT_W-1:0]  llMisses,
  output logic              spanErr
);
  strobes_t stb;
  trkStat_t iStat, dStat, llStat;

  miss_prof_control uCtrl (
    .clk(clk), .rst(rst), .iReq(iReq), .dReq(dReq),
    .iStat(iStat), .dStat(dStat), .llStat(llStat),
    .stb(stb), .iDone(iDone), .dDone(dDone));

  miss_prof_datapath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
    .IL_LOG2(IL_LOG2), .IS_LOG2(IS_LOG2), .IWAYS(IWAYS),
    .DL_LOG2(DL_LOG2), .DS_LOG2(DS_LOG2), .DWAYS(DWAYS),
    .LL_LOG2(LL_LOG2), .LS_LOG2(LS_LOG2), .LWAYS(LWAYS)) uData (
    .clk(clk), .rst(rst), .stb(stb),
    .iAddr(iAddr), .iSize(iSize), .dAddr(dAddr), .dSize(dSize),
    .iStat(iStat), .dStat(dStat), .llStat(llStat),
    .l1Misses(l1Misses), .llMisses(llMisses), .spanErr(spanErr));
endmodule

// File: rtl/miss_prof_checker.sv
module miss_prof_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             iDone,
  input logic             dDone,
  input logic [CNT_W-1:0] l1Misses,
  input logic [CNT_W-1:0] llMisses,
  input logic             spanErr
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    spanErr |=> spanErr); // R8

  AST_L1_STEP: assert property (@(posedge clk) disable iff (rst)
    (l1Misses - $past(l1Misses)) <= CNT_W'(2)); // R10

  AST_LL_STEP: assert property (@(posedge clk) disable iff (rst)
    (llMisses - $past(llMisses)) <= CNT_W'(1)); // R3

  AST_LL_NOT_AHEAD: assert property (@(posedge clk) disable iff (rst)
    llMisses <= l1Misses); // R4

  AST_LL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(llMisses) |-> (iDone || dDone)); // R7
endmodule

bind split_miss_profiler miss_prof_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .iDone(iDone), .dDone(dDone),
  .l1Misses(l1Misses), .llMisses(llMisses), .spanErr(spanErr));

// File: tb/sim_split_miss_profiler.sv
module sim_split_miss_profiler;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 4;
  localparam int CNT_W  = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic iReq = 1'b0, dReq = 1'b0;
  logic [ADDR_W-1:0] iAddr = '0, dAddr = '0;
  logic [SIZE_W-1:0] iSize = '0, dSize = '0;
  logic iDone, dDone, spanErr;
  logic [CNT_W-1:0] l1Misses, llMisses;

  typedef struct {
    bit isData;
    longint unsigned l1;
    longint unsigned ll;
    bit err;
    string tag;
  } expect_t;
  expect_t sbQ[$];
  int checks = 0, fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  split_miss_profiler u0 (
    .clk(clk), .rst(rst), .iReq(iReq), .iAddr(iAddr), .iSize(iSize),
    .dReq(dReq), .dAddr(dAddr), .dSize(dSize), .iDone(iDone), .dDone(dDone),
    .l1Misses(l1Misses), .llMisses(llMisses), .spanErr(spanErr));

  task automatic wrapUp();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic scoreDone(bit isData);
    expect_t e;
    checks++;
    if (sbQ.size() == 0) begin
      fails++;
      $display("FAIL R7: unexpected done on %s port, actual 1 expected 0", isData ? "data" : "instr");
      return;
    end
    e = sbQ.pop_front();
    if (e.isData != isData || l1Misses != e.l1 || llMisses != e.ll || spanErr != e.err) begin
      fails++;
      $display("FAIL %s: port=%0d l1=%0d ll=%0d err=%0d, expected port=%0d l1=%0d ll=%0d err=%0d",
               e.tag, isData, l1Misses, llMisses, spanErr, e.isData, e.l1, e.ll, e.err);
    end
  endtask

  // monitor: data done is scored first when both pulse together
  always @(negedge clk) begin
    if (!rst) begin
      if (dDone) scoreDone(1'b1);
      if (iDone) scoreDone(1'b0);
    end
  end

  task automatic push(bit isData, longint unsigned l1, longint unsigned ll, bit err, string tag);
    expect_t e;
    e.isData = isData; e.l1 = l1; e.ll = ll; e.err = err; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic waitDrain();
    while (sbQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sendD(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s,
                       longint unsigned l1, longint unsigned ll, bit err, string tag);
    push(1'b1, l1, ll, err, tag);
    @(negedge clk); dReq = 1'b1; dAddr = a; dSize = s;
    @(negedge clk); dReq = 1'b0;
    waitDrain();
  endtask

  task automatic sendI(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s,
                       longint unsigned l1, longint unsigned ll, bit err, string tag);
    push(1'b0, l1, ll, err, tag);
    @(negedge clk); iReq = 1'b1; iAddr = a; iSize = s;
    @(negedge clk); iReq = 1'b0;
    waitDrain();
  endtask

  task automatic checkVal(longint unsigned act, longint unsigned exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    wrapUp();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkVal(l1Misses, 0, "R9 reset l1");
    checkVal(llMisses, 0, "R9 reset ll");
    checkVal(spanErr, 0, "R9 reset err");

    sendD(16'h0000, 4, 1, 1, 0, "R3 cold miss both levels");
    sendD(16'h0004, 4, 1, 1, 0, "R4 L1 hit leaves ll alone");
    sendI(16'h0010, 4, 2, 1, 0, "R1 instr miss, shared ll hit");
    sendD(16'h001E, 4, 3, 2, 0, "R2 straddle two misses count once");
    sendD(16'h001E, 4, 3, 2, 0, "R2 straddle both hit");
    sendD(16'h002E, 4, 4, 2, 0, "R3 L1 straddle miss, ll single-line hit");
    sendI(16'h0007, 10, 4, 2, 1, "R8 three-line span");
    sendD(16'h0040, 1, 5, 3, 1, "R8 sticky err, R5 fill set");
    sendD(16'h0080, 1, 6, 4, 1, "R5 evict LRU");
    sendD(16'h0000, 1, 7, 4, 1, "R5 evicted line misses");
    sendD(16'h0080, 1, 7, 4, 1, "R5 recent line kept");
    sendD(16'h0040, 1, 8, 4, 1, "R5 LRU line evicted");

    // both ports miss together: data served first in the last level
    push(1'b1, 10, 5, 1, "R6 data first, R10 double count");
    push(1'b0, 10, 6, 1, "R6 instr after data");
    @(negedge clk);
    iReq = 1'b1; iAddr = 16'h0100; iSize = 1;
    dReq = 1'b1; dAddr = 16'h0200; dSize = 1;
    @(negedge clk); iReq = 1'b0; dReq = 1'b0;
    waitDrain();

    // second strobe while busy is ignored
    push(1'b1, 10, 6, 1, "R7 busy request ignored");
    @(negedge clk); dReq = 1'b1; dAddr = 16'h0040; dSize = 1;
    @(negedge clk); dAddr = 16'h0300;
    @(negedge clk); dReq = 1'b0;
    waitDrain();
    repeat (10) @(negedge clk);
    checkVal(l1Misses, 10, "R7 ignored strobe l1");
    checkVal(llMisses, 6, "R7 ignored strobe ll");

    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checkVal(l1Misses, 0, "R9 re-reset l1");
    checkVal(spanErr, 0, "R9 re-reset err");
    sendD(16'h0040, 1, 1, 1, 0, "R9 contents invalidated");

    wrapUp();
  end
endmodule